// File: doc/BRIEF.md
# Bidirectional Overcurrent Trip Latch

This block turns two raw overcurrent comparator flags, one for current flowing into the pack and one for current flowing out, into a latched disconnect command. A flag must stay up through a run of 1 ms ticks before the block acts, so short inrush surges pass. Once the run completes, the block latches a gate-inhibit output and turns on the enable for a resistor placed across the open switch pair. That resistor lets the block see when the load at the pack terminal has gone away.

The trip latch clears in two ways. A load-released indication, which shows that the terminal impedance has risen into the megohm range, clears it. A rising edge on the pack enable also clears it. Holding the enable low turns the bypass resistor off and leaves the trip in place. Both directions feed one shared persistence counter. Any cycle in which neither flag is up restarts the count, and both flags up together count as an excess.

Top module: `oc_trip_top`

## Requirements
- R1: After synchronous reset, `trip` and `bypass_en` are 0.
- R2: When `oc_chg` or `oc_dis` (or both) is 1 on every cycle from some cycle onward, `trip` becomes 1 in the cycle after the REJECT_MS-th cycle in which `tick_1ms` is 1 (default 6). Cycles without a tick do not add to the count.
- R3: A cycle in which both flags are 0 restarts the count from zero, so an excess that spans fewer than REJECT_MS ticks never sets `trip`.
- R4: The count is shared by both directions. A run in which `oc_chg` and `oc_dis` take turns, with at least one of them up on every cycle, trips just as a run of one flag does.
- R5: Once set, `trip` stays 1 whatever the flags do, until one of the clear conditions in R7 or R8 occurs.
- R6: `bypass_en` becomes 1 in the same cycle that `trip` becomes 1, unless `en_low` is 1 in the qualifying cycle. `bypass_en` is never 1 while `trip` is 0.
- R7: `load_released` = 1 while `trip` = 1 clears `trip` and `bypass_en` in the next cycle. `load_released` has no effect while `trip` = 0.
- R8: `en_rise` = 1 clears `trip`, `bypass_en` and the count in the next cycle. When the qualifying tick and `en_rise` fall in the same cycle, the clear wins and `trip` stays 0.
- R9: `en_low` = 1 clears `bypass_en` in the next cycle and leaves `trip` unchanged. The bypass stays off until the next trip.
- R10: While `trip` = 1 the flags are ignored. After a clear, a new trip needs a full run of REJECT_MS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| oc_chg | input | 1 | Charge-direction overcurrent comparator flag |
| oc_dis | input | 1 | Discharge-direction overcurrent comparator flag |
| load_released | input | 1 | High when the terminal impedance shows the load is gone |
| en_rise | input | 1 | One-cycle strobe on a low-to-high enable transition |
| en_low | input | 1 | Level, high while the enable is low |
| trip | output | 1 | Latched gate inhibit |
| bypass_en | output | 1 | Enable for the resistor across the open switch pair |

## Verification
Three pairs of functions can land in the same cycle:
- The qualifying tick that would set the trip and an enable-rise strobe.
- A trip being set and enable being held low.
- A trip and a load-released pulse on the cycle the trip appears.

The directed cases place these on the exact cycle of the REJECT_MS-th tick. They expect the clear to win over the set, and the trip to be set without its bypass. The random phase draws every input on every cycle, so these collisions also occur at random. There, a per-cycle bench model applies the same priorities and judges each output.

// File: rtl/oc_trip_pkg.sv
package oc_trip_pkg;

    typedef struct packed {
        logic chg;
        logic dis;
    } oc_flags_t;

    typedef enum logic {
        LATCH_CONDUCT = 1'b0,
        LATCH_TRIPPED = 1'b1
    } latch_state_t;

    typedef struct packed {
        logic set;
        logic clr;
    } latch_cmd_t;

    // Either direction, or both at once, counts as an excess.
    function automatic logic excess_of(input oc_flags_t f);
        return f.chg | f.dis;
    endfunction

endpackage

// File: rtl/oc_persist.sv
module oc_persist
    import oc_trip_pkg::*;
#(
    parameter int REJECT_MS = 6,
    localparam int CNT_W = (REJECT_MS < 2) ? 1 : $clog2(REJECT_MS)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_1ms,
    input  oc_flags_t flags,
    input  logic      hold_clear,
    output logic      qualify
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REJECT_MS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             exc;

    assign exc     = excess_of(flags);
    assign qualify = exc && tick_1ms && !hold_clear && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (hold_clear || !exc || qualify) begin
            cnt_q <= '0;
        end else if (tick_1ms) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (rst)
        !exc |=> (cnt_q == '0));
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    assert_cnt_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (exc && !tick_1ms && !hold_clear) |=> $stable(cnt_q));

endmodule

// File: rtl/oc_latch.sv
module oc_latch
    import oc_trip_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  latch_cmd_t cmd,
    output logic       tripped
);
    latch_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LATCH_CONDUCT;
        end else if (cmd.clr) begin
            st_q <= LATCH_CONDUCT;
        end else if (cmd.set) begin
            st_q <= LATCH_TRIPPED;
        end
    end

    assign tripped = (st_q == LATCH_TRIPPED);

    assert_trip_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tripped && !cmd.clr) |=> tripped);
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |=> !tripped);

endmodule

// File: rtl/oc_bypass.sv
module oc_bypass
    import oc_trip_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  latch_cmd_t cmd,
    input  logic       en_low,
    input  logic       tripped,
    output logic       bypass_en
);
    logic byp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q <= 1'b0;
        end else if (en_low || cmd.clr) begin
            byp_q <= 1'b0;
        end else if (cmd.set) begin
            byp_q <= 1'b1;
        end
    end

    assign bypass_en = byp_q;

    assert_bypass_needs_trip_R6: assert property (@(posedge clk) disable iff (rst)
        bypass_en |-> tripped);
    assert_en_low_kills_R9: assert property (@(posedge clk) disable iff (rst)
        en_low |=> !bypass_en);

endmodule

// File: rtl/oc_trip_top.sv
module oc_trip_top
    import oc_trip_pkg::*;
#(
    parameter int REJECT_MS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_1ms,
    input  logic oc_chg,
    input  logic oc_dis,
    input  logic load_released,
    input  logic en_rise,
    input  logic en_low,
    output logic trip,
    output logic bypass_en
);
    oc_flags_t  flags;
    latch_cmd_t cmd;
    logic       qualify;
    logic       tripped;

    assign flags.chg = oc_chg;
    assign flags.dis = oc_dis;

    // Clear has priority over set; a set is never raised while tripped.
    assign cmd.set = qualify;
    assign cmd.clr = en_rise | (tripped & load_released);

    oc_persist #(.REJECT_MS(REJECT_MS)) u_persist (
        .clk        (clk),
        .rst        (rst),
        .tick_1ms   (tick_1ms),
        .flags      (flags),
        .hold_clear (tripped | en_rise),
        .qualify    (qualify)
    );

    oc_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .tripped (tripped)
    );

    oc_bypass u_bypass (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .en_low    (en_low),
        .tripped   (tripped),
        .bypass_en (bypass_en)
    );

    assign trip = tripped;

    assert_load_release_R7: assert property (@(posedge clk) disable iff (rst)
        (trip && load_released) |=> !trip);
    assert_en_rise_clear_R8: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> (!trip && !bypass_en));
    assert_trip_ignores_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (trip && !en_rise && !load_released) |=> trip);

endmodule

// File: tb/tb_oc_trip_top.sv
module tb_oc_trip_top;
    localparam int CLK_PERIOD = 10;
    localparam int REJ = 6;

    logic clk = 1'b0;
    logic rst, tick_1ms, oc_chg, oc_dis, load_released, en_rise, en_low;
    logic trip, bypass_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int m_cnt;
    bit m_trip, m_byp;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_trip_top #(.REJECT_MS(REJ)) dut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .oc_chg(oc_chg),
        .oc_dis(oc_dis), .load_released(load_released), .en_rise(en_rise),
        .en_low(en_low), .trip(trip), .bypass_en(bypass_en)
    );

    function automatic bit qual_of(int cnt, bit trp, bit c, bit d, bit tk, bit er);
        return !trp && !er && (c | d) && tk && (cnt == REJ - 1);
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare after it.
    task automatic step(string req, bit tk, bit c, bit d, bit lr, bit er, bit el);
        bit q, clr;
        @(negedge clk);
        tick_1ms = tk; oc_chg = c; oc_dis = d;
        load_released = lr; en_rise = er; en_low = el;
        q   = qual_of(m_cnt, m_trip, c, d, tk, er);
        clr = er | (m_trip & lr);
        if (m_trip || er || !(c | d) || q) m_cnt = 0;
        else if (tk) m_cnt++;
        if (clr) m_trip = 0; else if (q) m_trip = 1;
        if (el || clr) m_byp = 0; else if (q) m_byp = 1;
        @(posedge clk); #1;
        check(req, trip, m_trip, "trip");
        check(req, bypass_en, m_byp, "bypass_en");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step("R1", 0, 0, 0, 0, 0, 0);
    endtask

    // Hold excess for k ticks (each tick separated by a non-tick cycle).
    task automatic run_ticks(string req, int k, bit c, bit d);
        for (int i = 0; i < k; i++) begin
            step(req, 0, c, d, 0, 0, 0);
            step(req, 1, c, d, 0, 0, 0);
        end
    endtask

    task automatic clear_by_rise();
        step("R8", 0, 0, 0, 0, 1, 0);
        check("R8", trip, 1'b0, "trip after en_rise");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 12345;
        void'($urandom(seed));
        rst = 1; tick_1ms = 0; oc_chg = 0; oc_dis = 0;
        load_released = 0; en_rise = 0; en_low = 0;
        m_cnt = 0; m_trip = 0; m_byp = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", trip, 1'b0, "trip at reset");
        check("R1", bypass_en, 1'b0, "bypass_en at reset");
        @(negedge clk); rst = 0;
        idle(2);

        // R2: charge flag for REJ ticks trips exactly after the last tick
        run_ticks("R2", REJ - 1, 1, 0);
        check("R2", trip, 1'b0, "no trip before last tick");
        run_ticks("R2", 1, 1, 0);
        check("R2", trip, 1'b1, "trip after REJ ticks");
        check("R6", bypass_en, 1'b1, "bypass with trip");
        // R5: flags drop, latch holds
        idle(5);
        check("R5", trip, 1'b1, "trip held");
        // R7: load released clears
        step("R7", 0, 0, 0, 1, 0, 0);
        check("R7", trip, 1'b0, "trip cleared by load release");
        check("R7", bypass_en, 1'b0, "bypass cleared by load release");
        // R7: load released with no trip has no effect on a later trip
        step("R7", 0, 0, 0, 1, 0, 0);
        check("R7", trip, 1'b0, "release while idle");

        // R3: short surges with gaps never trip
        for (int k = 0; k < 4; k++) begin
            run_ticks("R3", REJ - 1, 0, 1);
            step("R3", 0, 0, 0, 0, 0, 0);
        end
        check("R3", trip, 1'b0, "gapped surges no trip");

        // R4: alternating directions accumulate; both flags also count
        for (int i = 0; i < REJ; i++) begin
            step("R4", 0, 1, 1, 0, 0, 0);
            step("R4", 1, i[0], !i[0], 0, 0, 0);
        end
        check("R4", trip, 1'b1, "alternating flags trip");

        // R10: flags ignored while tripped; after clear a full run is needed
        run_ticks("R10", 3, 1, 1);
        clear_by_rise();
        run_ticks("R10", REJ - 1, 1, 0);
        check("R10", trip, 1'b0, "fresh count after clear");
        run_ticks("R10", 1, 1, 0);
        check("R10", trip, 1'b1, "trip after full fresh run");

        // R9: en_low kills bypass, trip stays, bypass stays off
        step("R9", 0, 0, 0, 0, 0, 1);
        check("R9", bypass_en, 1'b0, "bypass off on en_low");
        check("R9", trip, 1'b1, "trip kept on en_low");
        idle(3);
        check("R9", bypass_en, 1'b0, "bypass stays off");
        clear_by_rise();

        // R8: qualifying tick and en_rise in same cycle: clear wins
        run_ticks("R8", REJ - 1, 0, 1);
        step("R8", 0, 0, 1, 0, 0, 0);
        step("R8", 1, 0, 1, 0, 1, 0);
        check("R8", trip, 1'b0, "en_rise beats qualify");
        run_ticks("R8", REJ - 1, 0, 1);
        check("R8", trip, 1'b0, "count restarted by en_rise");
        run_ticks("R8", 1, 0, 1);
        check("R8", trip, 1'b1, "trip after restart");
        clear_by_rise();

        // R6: trip with en_low in the qualifying cycle sets no bypass
        run_ticks("R6", REJ - 1, 1, 0);
        step("R6", 0, 1, 0, 0, 0, 1);
        step("R6", 1, 1, 0, 0, 0, 1);
        check("R6", trip, 1'b1, "trip under en_low");
        check("R6", bypass_en, 1'b0, "no bypass under en_low");
        clear_by_rise();

        // Random phase against the per-cycle model
        for (int i = 0; i < 20000; i++) begin
            bit tk, c, d, lr, er, el;
            tk = ($urandom % 3) == 0;
            c  = ($urandom % 8) != 0;
            d  = ($urandom % 4) == 0;
            lr = ($urandom % 40) == 0;
            er = ($urandom % 60) == 0;
            el = ($urandom % 30) == 0;
            step("R2", tk, c, d, lr, er, el);
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule